// File: doc/BRIEF.md
# Indexed Store-Immediate Bus Sequencer

The block runs the memory cycles of an indexed store-immediate operation once the opcode has already been fetched and decoded elsewhere. On a start strobe it takes the current program counter and the index register value. It reads a signed offset byte at the program counter and then an immediate byte at the next address. It adds the sign-extended offset to the index value to get a target address, and it writes the immediate byte there. Each pass ends with a one-clock done strobe, and the program counter output has then advanced by two.

The block is clocked at twice the bus state rate. One bus clock (T-state) is two ticks of `clk`, a first half and a second half, so strobes can change in the middle of a T-state. The T-state order is fixed. T0 to T2 read the offset and T3 to T5 read the immediate, with no gap between the two reads. T6 and T7 are address-computation clocks with no memory request. T8 to T10 are the write and T11 is the done clock. The cycle counter output shows the current T-state number.

Top module: `idx_store_seq`

## Requirements
- R1: While reset is high and after its release, mem_mreq, mem_rd, mem_wr and done are 0, cyc_cnt is 0 and pc_out is 0.
- R2: The offset read covers T0 to T2 at the start PC. mem_mreq and mem_rd are 1 from the second half of T0 through the first half of T2 and 0 otherwise. pc_out becomes start PC + 1 from the second half of T0. The byte is taken at the end of T2.
- R3: The immediate read covers T3 to T5 at start PC + 1, modulo 2^16, directly after the offset read. Its strobe pattern matches R2 shifted by three T-states. pc_out becomes start PC + 2 from the second half of T3.
- R4: During T6 and T7, mem_mreq, mem_rd and mem_wr are all 0.
- R5: The target address equals the index plus the offset read as an 8-bit two's-complement value, modulo 2^16. Offsets 80h to FFh therefore subtract (1000h + 03h = 1003h, 1000h + 80h = 0F80h).
- R6: The write covers T8 to T10 with mem_addr equal to the target address throughout. mem_mreq and mem_wr are 1 in both halves of T9 only, and mem_wdata equals the immediate byte from T8 to T10.
- R7: done is 1 for both halves of T11 and 0 at all other times. After T11 all strobes stay 0 and pc_out stays at start PC + 2.
- R8: During a pass, cyc_cnt equals the current T-state number (0 to 11). After the pass it holds 12 until the next start.
- R9: A start strobe that arrives while a pass is running is ignored. The running pass keeps its addresses, data and timing.
- R10: mem_rd and mem_wr are never 1 together, and each implies mem_mreq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-T-state tick clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a pass when idle |
| pc_in | input | 16 | Program counter at start |
| index_in | input | 16 | Index register value at start |
| pc_out | output | 16 | Advancing program counter |
| mem_addr | output | 16 | Memory address bus |
| mem_rdata | input | 8 | Read data from memory |
| mem_wdata | output | 8 | Write data to memory |
| mem_mreq | output | 1 | Memory request strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| cyc_cnt | output | 4 | Current T-state number |
| done | output | 1 | End-of-pass pulse |

## Verification
Faults in the tick counter or the half-state flag show up at the ports within one tick. Strobes appear in the wrong half-state, the idle clocks drift into or out of the read window, or cyc_cnt skips a value. A wrongly captured offset or immediate byte, or a wrong sign extension, shows no effect until T8, when mem_addr or mem_wdata carries the wrong value through the whole write. The offset values 7Fh, 80h and FFh, together with wrap at the top of the address space, tell sign extension apart from zero extension. A start accepted by mistake during a pass changes the read address or the cycle count within two ticks.

// File: rtl/iss_pkg.sv
package iss_pkg;

    typedef enum logic [2:0] {
        STEP_IDLE,
        STEP_RD_OFS,
        STEP_RD_IMM,
        STEP_CALC,
        STEP_WRITE,
        STEP_DONE
    } step_e;

    typedef struct packed {
        logic mreq;
        logic rd;
        logic wr;
    } bus_ctl_t;

    function automatic logic [15:0] sext8to16(input logic [7:0] b);
        return {{8{b[7]}}, b};
    endfunction

endpackage

// File: rtl/iss_timer.sv
module iss_timer
    import iss_pkg::*;
#(
    parameter int RD_T   = 3,
    parameter int IDLE_T = 2,
    parameter int WR_T   = 3,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             accept,
    output logic             active,
    output logic             half,
    output logic [CNT_W-1:0] tcnt,
    output step_e            step,
    output logic [CNT_W-1:0] toff
);
    localparam int IMM_BEG  = RD_T;
    localparam int CALC_BEG = 2 * RD_T;
    localparam int WR_BEG   = CALC_BEG + IDLE_T;
    localparam int DONE_T   = WR_BEG + WR_T;

    assign accept = start && !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            half   <= 1'b0;
            tcnt   <= '0;
        end else if (accept) begin
            active <= 1'b1;
            half   <= 1'b0;
            tcnt   <= '0;
        end else if (active) begin
            if (!half) begin
                half <= 1'b1;
            end else begin
                half <= 1'b0;
                tcnt <= tcnt + 1'b1;
                if (int'(tcnt) == DONE_T) active <= 1'b0;
            end
        end
    end

    always_comb begin
        step = STEP_IDLE;
        toff = '0;
        if (active) begin
            if (int'(tcnt) < IMM_BEG) begin
                step = STEP_RD_OFS;
                toff = tcnt;
            end else if (int'(tcnt) < CALC_BEG) begin
                step = STEP_RD_IMM;
                toff = tcnt - CNT_W'(IMM_BEG);
            end else if (int'(tcnt) < WR_BEG) begin
                step = STEP_CALC;
                toff = tcnt - CNT_W'(CALC_BEG);
            end else if (int'(tcnt) < DONE_T) begin
                step = STEP_WRITE;
                toff = tcnt - CNT_W'(WR_BEG);
            end else begin
                step = STEP_DONE;
                toff = '0;
            end
        end
    end
endmodule

// File: rtl/iss_datapath.sv
module iss_datapath
    import iss_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RD_T   = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              active,
    input  logic              half,
    input  step_e             step,
    input  logic [CNT_W-1:0]  toff,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] index_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] ea_q,
    output logic [DATA_W-1:0] imm_q
);
    logic [ADDR_W-1:0] idx_q;
    logic [DATA_W-1:0] ofs_q;
    logic              in_read;

    assign in_read = (step == STEP_RD_OFS) || (step == STEP_RD_IMM);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            base_q <= '0;
            idx_q  <= '0;
            ofs_q  <= '0;
            imm_q  <= '0;
            ea_q   <= '0;
        end else if (accept) begin
            pc_q   <= pc_in;
            base_q <= pc_in;
            idx_q  <= index_in;
        end else if (active) begin
            if (in_read && !half && toff == '0)
                pc_q <= pc_q + 1'b1;
            if (in_read && half && int'(toff) == RD_T - 1) begin
                if (step == STEP_RD_OFS) ofs_q <= rdata;
                else                     imm_q <= rdata;
            end
            if (step == STEP_CALC && half && toff == '0)
                ea_q <= idx_q + ADDR_W'(sext8to16(ofs_q));
        end
    end
endmodule

// File: rtl/iss_busmux.sv
module iss_busmux
    import iss_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RD_T   = 3,
    parameter int WR_T   = 3,
    parameter int CNT_W  = 4
) (
    input  step_e             step,
    input  logic [CNT_W-1:0]  toff,
    input  logic              half,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [ADDR_W-1:0] ea_q,
    output logic [ADDR_W-1:0] addr,
    output bus_ctl_t          ctl
);
    logic rd_win;
    logic wr_win;
    int   k;

    always_comb begin
        k = int'(toff);
        rd_win = ((k == 0) && half) || ((k > 0) && (k < RD_T - 1)) ||
                 ((k == RD_T - 1) && !half);
        wr_win = (k > 0) && (k < WR_T - 1);
        ctl = '0;
        addr = ea_q;
        case (step)
            STEP_RD_OFS: begin
                addr   = base_q;
                ctl.rd = rd_win;
            end
            STEP_RD_IMM: begin
                addr   = base_q + 1'b1;
                ctl.rd = rd_win;
            end
            STEP_CALC: addr = base_q + 1'b1;
            STEP_WRITE: ctl.wr = wr_win;
            default: ;
        endcase
        ctl.mreq = ctl.rd || ctl.wr;
    end
endmodule

// File: rtl/idx_store_seq.sv
module idx_store_seq
    import iss_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RD_T   = 3,
    parameter int IDLE_T = 2,
    parameter int WR_T   = 3,
    localparam int TOTAL_T = 2 * RD_T + IDLE_T + WR_T + 1,
    localparam int CNT_W   = $clog2(TOTAL_T + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] index_in,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_mreq,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [CNT_W-1:0]  cyc_cnt,
    output logic              done
);
    logic              accept, active, half;
    logic [CNT_W-1:0]  tcnt, toff;
    step_e             step;
    logic [ADDR_W-1:0] base_q, ea_q;
    logic [DATA_W-1:0] imm_q;
    bus_ctl_t          ctl;

    iss_timer #(.RD_T(RD_T), .IDLE_T(IDLE_T), .WR_T(WR_T), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .start(start), .accept(accept), .active(active),
        .half(half), .tcnt(tcnt), .step(step), .toff(toff)
    );

    iss_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_T(RD_T), .CNT_W(CNT_W)) u_dp (
        .clk(clk), .rst(rst), .accept(accept), .active(active), .half(half),
        .step(step), .toff(toff), .pc_in(pc_in), .index_in(index_in),
        .rdata(mem_rdata), .pc_q(pc_out), .base_q(base_q), .ea_q(ea_q), .imm_q(imm_q)
    );

    iss_busmux #(.ADDR_W(ADDR_W), .RD_T(RD_T), .WR_T(WR_T), .CNT_W(CNT_W)) u_mux (
        .step(step), .toff(toff), .half(half), .base_q(base_q), .ea_q(ea_q),
        .addr(mem_addr), .ctl(ctl)
    );

    assign mem_mreq  = ctl.mreq;
    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;
    assign mem_wdata = imm_q;
    assign cyc_cnt   = tcnt;
    assign done      = (step == STEP_DONE);
endmodule

// File: rtl/idx_store_seq_chk.sv
module idx_store_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] pc_out,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_mreq,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [CNT_W-1:0]  cyc_cnt,
    input logic              done
);
    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));

    // R10
    strobe_mreq_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> mem_mreq);

    // R2
    rd_pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd) |-> (pc_out == $past(pc_out) + 1'b1));

    // R6
    wr_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $stable(mem_addr));

    // R7
    done_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |=> done);

    // R7
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |=> !done);

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_cnt != $past(cyc_cnt) && cyc_cnt != '0) |-> (cyc_cnt == $past(cyc_cnt) + 1'b1));
endmodule

bind idx_store_seq idx_store_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .pc_out(pc_out), .mem_addr(mem_addr), .mem_mreq(mem_mreq),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .cyc_cnt(cyc_cnt), .done(done)
);

// File: tb/sim_idx_store_seq.sv
module sim_idx_store_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0, index_in = '0;
    logic [15:0] pc_out, mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;
    logic        mem_mreq, mem_rd, mem_wr, done;
    logic [3:0]  cyc_cnt;

    logic [15:0] cur_pc = '0;
    logic [7:0]  cur_d = '0, cur_n = '0;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    idx_store_seq u0 (
        .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .index_in(index_in),
        .pc_out(pc_out), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_mreq(mem_mreq), .mem_rd(mem_rd), .mem_wr(mem_wr), .cyc_cnt(cyc_cnt), .done(done)
    );

    always_comb begin
        if (mem_addr == cur_pc)                     mem_rdata = cur_d;
        else if (mem_addr == 16'(cur_pc + 16'd1))   mem_rdata = cur_n;
        else                                        mem_rdata = 8'h5A;
    end

    // {pc, index, offset, immediate}
    localparam logic [47:0] VEC [6] = '{
        {16'h0006, 16'h1000, 8'h03, 8'h0B},
        {16'h2000, 16'h1000, 8'h80, 8'hC4},
        {16'h0100, 16'h4000, 8'hFF, 8'h11},
        {16'h0200, 16'h4000, 8'h7F, 8'hE7},
        {16'hFFFF, 16'h8000, 8'h10, 8'h3C},
        {16'h1234, 16'h0000, 8'hFE, 8'h99}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_op(input logic [15:0] pc, input logic [15:0] idx,
                          input logic [7:0] d, input logic [7:0] n, input int inject);
        logic [15:0] ea;
        ea = 16'(idx + {{8{d[7]}}, d});
        cur_pc = pc; cur_d = d; cur_n = n;
        @(negedge clk);
        start = 1'b1; pc_in = pc; index_in = idx;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 24; i++) begin
            int t = i / 2;
            bit h = (i % 2) == 1;
            bit erd = ((t == 0 || t == 3) && h) || t == 1 || t == 4 || ((t == 2 || t == 5) && !h);
            bit ewr = (t == 9);
            logic [15:0] eaddr = (t < 3) ? pc : (t < 8) ? 16'(pc + 16'd1) : ea;
            logic [15:0] epc = (t == 0 && !h) ? pc :
                               (t < 3 || (t == 3 && !h)) ? 16'(pc + 16'd1) : 16'(pc + 16'd2);
            // R2 R3 R4 R6: read/idle/write strobes
            chk(mem_rd == erd, "R2/R3 rd", int'(mem_rd), int'(erd));
            chk(mem_wr == ewr, "R4/R6 wr", int'(mem_wr), int'(ewr));
            chk(mem_mreq == (erd | ewr), "R4 mreq", int'(mem_mreq), int'(erd | ewr));
            if (t < 6 || t >= 8)
                chk(mem_addr == eaddr, "R5 addr", int'(mem_addr), int'(eaddr));
            chk(pc_out == epc, "R3 pc_out", int'(pc_out), int'(epc));
            chk(done == (t == 11), "R7 done", int'(done), int'(t == 11));
            chk(int'(cyc_cnt) == t, "R8 cyc_cnt", int'(cyc_cnt), t);
            if (t >= 8 && t <= 10)
                chk(mem_wdata == n, "R6 wdata", int'(mem_wdata), int'(n));
            if (i == inject) begin
                start = 1'b1; pc_in = 16'hBEEF; index_in = 16'h7777;  // R9
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(cyc_cnt == 4'd12, "R8 hold", int'(cyc_cnt), 12);
        chk(!done && !mem_mreq, "R7 after", int'({done, mem_mreq}), 0);
        chk(pc_out == 16'(pc + 16'd2), "R7 pc_out", int'(pc_out), int'(16'(pc + 16'd2)));
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: under reset
        chk({mem_mreq, mem_rd, mem_wr, done} == 4'b0, "R1 strobes", int'({mem_mreq, mem_rd, mem_wr, done}), 0);
        chk(cyc_cnt == 0 && pc_out == 0, "R1 regs", int'(pc_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cyc_cnt == 0 && pc_out == 0 && !done, "R1 released", int'(cyc_cnt), 0);
        for (int v = 0; v < 6; v++)
            run_op(VEC[v][47:32], VEC[v][31:16], VEC[v][15:8], VEC[v][7:0], -1);
        // R5: explicit targets for sign cases
        run_op(16'h0500, 16'h1000, 8'h80, 8'h42, -1);
        chk(mem_addr == 16'h0F80, "R5 negative offset", int'(mem_addr), 16'h0F80);
        // R9: start during reads, idle and write clocks
        run_op(16'h0006, 16'h1000, 8'h03, 8'h0B, 5);
        run_op(16'h0030, 16'h2000, 8'hF0, 8'hA5, 13);
        run_op(16'h0040, 16'h3000, 8'h01, 8'h5E, 17);
        // back-to-back start right after a pass
        run_op(16'h7FFF, 16'hFF80, 8'h80, 8'h01, -1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule